// File: doc/BRIEF.md
# Interleaved Multiphase PWM Sequencer

The sequencer drives up to six gate-command outputs for a multiphase buck regulator from one shared switching-period counter. Every active phase fires once per period. The phase starts are spread evenly across the period, so the ripple of the phases interleaves. The number of active phases is not programmed by a register. It is taken from a strap vector that reports which output lines are tied high on the board. Each output is a three-level command on two bits: low, high, or mid-level. The mid-level tells a downstream driver to float both switches.

A shedding controller supplies a per-phase enable mask and a per-phase idle level. A phase whose mask bit is cleared shows the requested idle level instead of its pulse. Its internal timing keeps running, so the interleave is intact when the phase is re-enabled. The pulse width is a clock count. Each phase captures it only at the start of its own sub-period, so a width change never cuts a pulse short.

Top module: `mpwm_seq`

## Requirements
- R1: The active phase count N is MAX_PH minus the number of contiguous strap bits set, counting down from the top bit (bit MAX_PH-1) and stopping at bit 1. Bit 0 is never counted. An all-zero strap gives N = MAX_PH (6), and a strap with bits 1 through 5 set gives N = 1.
- R2: Each two-bit output field uses the codes 2'b00 = low, 2'b01 = high and 2'b10 = mid-level. The code 2'b11 never appears on an output. Phase k occupies bits [2k+1:2k] of `pwm_o`.
- R3: The period counter counts 0, 1, …, period-1 and then returns to 0. `period_i` is given in clocks and is at least MAX_PH.
- R4: Phase k (0-based, k < N) starts when the counter equals k*floor(period/N). Its output is high from the clock after that counter value, for exactly duty clocks. A duty of 0 gives no pulse, and a duty at or above the period holds the output high.
- R5: Phase 0 starts first after reset, and the phases follow in ascending index order. The last active phase absorbs the division remainder, so its window runs from (N-1)*floor(period/N) to the end of the period.
- R6: A phase samples `duty_i` only in the clock of its own start. A duty change that arrives between two starts affects only the pulses that begin after it.
- R7: Outputs with index k ≥ N are held at mid-level (2'b10) and never pulse.
- R8: An active phase with its `en_i` bit cleared outputs its field of `idle_lvl_i`. A requested 2'b11 is shown as mid-level.
- R9: While `rst_n` is low, the counter and all pulse timers are cleared. Active, enabled outputs show low, and the other outputs follow R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | CNT_W | Switching period in clocks (≥ MAX_PH) |
| duty_i | input | CNT_W | High time per pulse in clocks |
| strap_i | input | MAX_PH | Bit i set when output i is tied high (phase-count strap) |
| en_i | input | MAX_PH | Per-phase enable from the shedding controller |
| idle_lvl_i | input | 2*MAX_PH | Per-phase level shown while the phase is masked |
| pwm_o | output | 2*MAX_PH | Per-phase three-level command |

## Verification
The hardest case to reach from the ports is a duty change that arrives while some phases are in the middle of a pulse and others have not yet started. Each phase must then finish with its old width and pick up the new width only at its own next start. The bench reaches this by changing `duty_i` at a chosen clock inside a period whose length does not divide evenly by N. The expected width of every pulse is derived from whether that pulse's start came before or after the change. The same periods also exercise the lengthened window of the last phase. The bench sweeps all phase counts against a range of periods and duties.

// File: rtl/mpwm_pkg.sv
// Shared definitions for the multiphase PWM sequencer.
// Assumes: two-bit three-level output encoding used by all modules.
package mpwm_pkg;
    typedef enum logic [1:0] {
        LVL_LO  = 2'b00,
        LVL_HI  = 2'b01,
        LVL_MID = 2'b10
    } lvl_e;
endpackage

// File: rtl/mpwm_strap_dec.sv
// Decodes the phase-count strap into the number of active phases.
// Assumes: straps tie the top outputs high contiguously; bit 0 is never a strap.
module mpwm_strap_dec #(
    parameter int MAX_PH = 6,
    localparam int NW    = $clog2(MAX_PH + 1)
) (
    input  logic [MAX_PH-1:0] strap_i,
    output logic [NW-1:0]     n_act_o
);
    // Count contiguous tied-high bits from the top, stopping at bit 1.
    always_comb begin
        logic         run;
        logic [NW-1:0] tied;
        run  = 1'b1;
        tied = '0;
        for (int i = MAX_PH - 1; i >= 1; i--) begin
            if (run && strap_i[i]) tied = tied + 1'b1;
            else                   run  = 1'b0;
        end
        n_act_o = NW'(MAX_PH) - tied;
    end
endmodule

// File: rtl/mpwm_slot_gen.sv
// Shared period counter and per-phase start strobes.
// Assumes: period_i >= MAX_PH and n_act_i in 1..MAX_PH; phase k starts at
// k*floor(period/N), so the last phase absorbs the remainder.
module mpwm_slot_gen #(
    parameter int MAX_PH = 6,
    parameter int CNT_W  = 12,
    localparam int NW    = $clog2(MAX_PH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [NW-1:0]     n_act_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [MAX_PH-1:0] start_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step;

    // Wrap the period counter at period-1.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (cnt_q >= period_i - 1'b1)       cnt_q <= '0;
        else                                     cnt_q <= cnt_q + 1'b1;
    end

    // Spacing between consecutive phase starts.
    always_comb step = period_i / CNT_W'(n_act_i);

    for (genvar k = 0; k < MAX_PH; k++) begin : g_start
        logic [CNT_W-1:0] offset;
        // Offset of this phase inside the period.
        always_comb offset = CNT_W'(k) * step;
        // Strobe the start when the counter reaches the offset.
        always_comb start_o[k] = (NW'(k) < n_act_i) && (cnt_q == offset);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/mpwm_phase_drv.sv
// One phase: pulse timer loaded with the duty at its own start, plus level select.
// Assumes: start_i lasts one clock per period; idle code 2'b11 maps to mid-level.
module mpwm_phase_drv
    import mpwm_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             active_i,
    input  logic             en_i,
    input  logic [1:0]       idle_i,
    output logic [1:0]       lvl_o
);
    logic [CNT_W-1:0] rem_q;

    // Load the duty at start, otherwise count the pulse down.
    always_ff @(posedge clk) begin
        if (!rst_n)           rem_q <= '0;
        else if (start_i)     rem_q <= duty_i;
        else if (rem_q != '0) rem_q <= rem_q - 1'b1;
    end

    // Pick the output level: unused, masked, or pulsing.
    always_comb begin
        if (!active_i)             lvl_o = LVL_MID;
        else if (!en_i)            lvl_o = (idle_i == 2'b11) ? LVL_MID : idle_i;
        else if (rem_q != '0)      lvl_o = LVL_HI;
        else                       lvl_o = LVL_LO;
    end
endmodule

// File: rtl/mpwm_seq.sv
// Top: interleaved multiphase PWM sequencer with strap-derived phase count.
// Assumes: period_i >= MAX_PH; inputs synchronous to clk.
module mpwm_seq #(
    parameter int MAX_PH = 6,
    parameter int CNT_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      period_i,
    input  logic [CNT_W-1:0]      duty_i,
    input  logic [MAX_PH-1:0]     strap_i,
    input  logic [MAX_PH-1:0]     en_i,
    input  logic [2*MAX_PH-1:0]   idle_lvl_i,
    output logic [2*MAX_PH-1:0]   pwm_o
);
    localparam int NW = $clog2(MAX_PH + 1);

    logic [NW-1:0]     n_act;
    logic [CNT_W-1:0]  cnt;
    logic [MAX_PH-1:0] start;

    mpwm_strap_dec #(.MAX_PH(MAX_PH)) dec_i (
        .strap_i (strap_i),
        .n_act_o (n_act)
    );

    mpwm_slot_gen #(.MAX_PH(MAX_PH), .CNT_W(CNT_W)) slot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (period_i),
        .n_act_i  (n_act),
        .cnt_o    (cnt),
        .start_o  (start)
    );

    for (genvar k = 0; k < MAX_PH; k++) begin : g_ph
        logic act;
        // Phase is in use when its index is below the strapped count.
        always_comb act = NW'(k) < n_act;
        mpwm_phase_drv #(.CNT_W(CNT_W)) drv_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start[k]),
            .duty_i   (duty_i),
            .active_i (act),
            .en_i     (en_i[k]),
            .idle_i   (idle_lvl_i[2*k +: 2]),
            .lvl_o    (pwm_o[2*k +: 2])
        );
    end
endmodule

// File: rtl/mpwm_seq_chk.sv
// Assertion checker for mpwm_seq, attached by bind.
// Assumes: sees the decoded phase count and period counter of the top.
module mpwm_seq_chk #(
    parameter int MAX_PH = 6,
    parameter int CNT_W  = 12,
    localparam int NW    = $clog2(MAX_PH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [MAX_PH-1:0]   en_i,
    input logic [2*MAX_PH-1:0] idle_lvl_i,
    input logic [2*MAX_PH-1:0] pwm_o,
    input logic [NW-1:0]       n_act_i,
    input logic [CNT_W-1:0]    cnt_i
);
    // R1: decoded count always within 1..MAX_PH
    a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (n_act_i >= NW'(1)) && (n_act_i <= NW'(MAX_PH)));

    // R3: counter either advances by one or returns to zero
    a_r3_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_i == '0) || (cnt_i == $past(cnt_i) + 1'b1));

    for (genvar k = 0; k < MAX_PH; k++) begin : g_chk
        // R2: illegal code never driven
        a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
            pwm_o[2*k +: 2] != 2'b11);
        // R7: unused phases stay mid-level
        a_r7_unused_mid: assert property (@(posedge clk) disable iff (!rst_n)
            (NW'(k) >= n_act_i) |-> pwm_o[2*k +: 2] == 2'b10);
        // R8: masked active phase shows a non-pulsing level chosen outside
        a_r8_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
            ((NW'(k) < n_act_i) && !en_i[k] && (idle_lvl_i[2*k +: 2] != 2'b01))
            |-> pwm_o[2*k +: 2] != 2'b01);
    end
endmodule

bind mpwm_seq mpwm_seq_chk #(.MAX_PH(MAX_PH), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .idle_lvl_i (idle_lvl_i),
    .pwm_o      (pwm_o),
    .n_act_i    (n_act),
    .cnt_i      (cnt)
);

// File: tb/mpwm_seq_tb_top.sv
// Self-checking bench: sweeps strap, period and duty; expected levels computed
// arithmetically from posedge index since reset release.
module mpwm_seq_tb_top;
    localparam int MAX_PH = 6;
    localparam int CNT_W  = 12;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [CNT_W-1:0]      period_i = CNT_W'(12);
    logic [CNT_W-1:0]      duty_i = '0;
    logic [MAX_PH-1:0]     strap_i = '0;
    logic [MAX_PH-1:0]     en_i = '1;
    logic [2*MAX_PH-1:0]   idle_lvl_i = '0;
    logic [2*MAX_PH-1:0]   pwm_o;

    int checks = 0;
    int errors = 0;
    int jcnt   = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Model state for the running configuration.
    int m_p, m_d0, m_d1, m_jc;

    mpwm_seq #(.MAX_PH(MAX_PH), .CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_i   (period_i),
        .duty_i     (duty_i),
        .strap_i    (strap_i),
        .en_i       (en_i),
        .idle_lvl_i (idle_lvl_i),
        .pwm_o      (pwm_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Count posedges seen with reset released.
    always @(posedge clk) begin
        if (!rst_n) jcnt <= 0;
        else        jcnt <= jcnt + 1;
    end

    // Watchdog: hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // R1: expected phase count from the strap.
    function automatic int exp_n(input logic [MAX_PH-1:0] st);
        int t = 0;
        for (int i = MAX_PH - 1; i >= 1; i--) begin
            if (st[i]) t++;
            else break;
        end
        return MAX_PH - t;
    endfunction

    // Compare every phase field against the arithmetic model.
    task automatic check_all(input string tag);
        int n = exp_n(strap_i);
        for (int k = 0; k < MAX_PH; k++) begin
            logic [1:0] exp;
            logic [1:0] got = pwm_o[2*k +: 2];
            if (k >= n) exp = 2'b10;                              // R7
            else if (!en_i[k])                                    // R8
                exp = (idle_lvl_i[2*k +: 2] == 2'b11) ? 2'b10 : idle_lvl_i[2*k +: 2];
            else if (jcnt == 0) exp = 2'b00;                      // R9
            else begin
                int j   = jcnt - 1;
                int off = k * (m_p / n);                          // R4, R5
                if (j < off) exp = 2'b00;
                else begin
                    int r = (j - off) % m_p;
                    int s = j - r;
                    int d = (s >= m_jc) ? m_d1 : m_d0;           // R6
                    exp = (r < d) ? 2'b01 : 2'b00;                // R2 codes
                end
            end
            checks++;
            if (got !== exp) begin
                errors++;
                $display("FAIL %s phase %0d t=%0d: actual=%b expected=%b", tag, k, jcnt, got, exp);
            end
        end
    endtask

    // Reset, apply one configuration and check for ncyc clocks.
    task automatic run_cfg(input logic [MAX_PH-1:0] st, input int p, input int d0,
                           input int d1, input int jc, input logic [MAX_PH-1:0] en,
                           input logic [2*MAX_PH-1:0] idle, input int ncyc,
                           input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        strap_i = st; period_i = CNT_W'(p); duty_i = CNT_W'(d0);
        en_i = en; idle_lvl_i = idle;
        m_p = p; m_d0 = d0; m_d1 = d1; m_jc = jc;
        @(negedge clk);
        @(negedge clk);
        check_all("R9 reset");
        rst_n = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            check_all(tag);
            if (jcnt == jc) duty_i = CNT_W'(d1);
        end
    endtask

    initial begin
        // R1 R3 R4 R5 R7: sweep tied-strap depth, period and duty.
        for (int t = 0; t < MAX_PH; t++) begin
            logic [MAX_PH-1:0] st = '0;
            for (int b = 0; b < t; b++) st[MAX_PH-1-b] = 1'b1;
            for (int p = 6; p <= 14; p++) begin
                int dl [4] = '{0, 1, p / 3, p};
                foreach (dl[i])
                    run_cfg(st, p, dl[i], dl[i], 1 << 30, '1, '0, 3 * p + 2, "R4 sweep");
            end
        end
        // R1: bit 0 ignored, non-contiguous strap keeps full count.
        run_cfg(6'b111111, 8, 3, 3, 1 << 30, '1, '0, 20, "R1 bit0");
        run_cfg(6'b010000, 13, 2, 2, 1 << 30, '1, '0, 40, "R1 gap");
        // R5: remainder on the last phase (13/6 -> step 2, last window 3).
        run_cfg(6'b000000, 13, 3, 3, 1 << 30, '1, '0, 40, "R5 remainder");
        // R4: duty above period holds high.
        run_cfg(6'b111110, 8, 9, 9, 1 << 30, '1, '0, 30, "R4 full");
        // R6: duty change mid-period at several points.
        for (int jc = 3; jc < 17; jc += 3)
            run_cfg(6'b000000, 13, 2, 5, jc, '1, '0, 50, "R6 latch");
        run_cfg(6'b100000, 11, 6, 1, 7, '1, '0, 40, "R6 shrink");
        // R8: masked phases, including the 2'b11 request.
        run_cfg(6'b110000, 12, 2, 2, 1 << 30, 6'b111010,
                12'b00_00_00_11_00_01, 30, "R8 mask");
        run_cfg(6'b000000, 12, 4, 4, 1 << 30, 6'b010101,
                12'b10_00_01_00_11_00, 30, "R8 mask2");
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule